// File: doc/BRIEF.md
# Debug Link Entry and Unlock Sequencer

This block brings a two-wire serial debug link from an idle, undriven state into a state where the target's non-volatile memory controller can be used. It also takes the link back out of that state. The link is entered at pin level. The sequencer enables its clock and data outputs with data low and clock high, then raises data. After a programmable settle time it gives a train of clock pulses. From then on, every byte goes through an external frame transceiver, using a request/done handshake. First comes a control-register store that configures the link. Next comes a reset write, then the key command followed by an eight-byte key. Last comes a bounded readiness poll: each attempt sends one command byte and reads back one status byte.

The exit sequence releases the target reset. It then stores a no-operation command into the target's memory command register, using a direct-store frame whose four address bytes place it at the command register. Finally it parks the pins with data low and clock high. Each sequence ends with a one-cycle `done` pulse. A 3-bit code reports the result: 0 means success, 1 means a read error during polling, 2 means the poll timed out. The code stays valid until the next request is accepted.

Top module: `dbg_unlock_seq`

## Requirements
- R1: After reset the block is idle: `busy`, `done`, `errFlag`, `unlocked`, `pinOe`, `pinData`, `txReq` and `rxReq` are 0; `errCode` is 0; `pinClk` and `pinOwn` are 1.
- R2: An accepted `startReq` first sets `pinOe`=1 with `pinData`=0 and `pinClk`=1. Data is then raised and held high for at least `DELAY_CYCLES` clocks before any clock activity. Then exactly `PULSE_COUNT` low pulses appear on `pinClk` while `pinData` stays high.
- R3: After the pulses the first two bytes offered on `txByte` are 0xC2 then 0x02. Each byte is held stable with `txReq` high until `txDone`.
- R4: The next bytes are 0xC1, 0x59, 0xE0 and then the key FF, 88, D8, CD, 45, AB, 89, 12, in exactly this order. That makes 13 bytes before polling.
- R5: Each poll attempt sends 0x80 and then raises `rxReq` for one status byte. `txReq` and `rxReq` are never high together. A status byte with bit 1 (mask 0x02) set ends the sequence with `errCode`=0 and `unlocked`=1.
- R6: If `POLL_LIMIT` (256) attempts all return bit 1 clear, the sequence ends with `errCode`=2 and `errFlag`=1. Success on the last allowed attempt still gives code 0.
- R7: A status read returned with `rxErr`=1 ends the sequence on the next cycle with `errCode`=1. No further poll is sent, whatever the status value.
- R8: An accepted `exitReq` sends 0xC1, 0x00, 0x4C, 0xCA, 0x01, 0x00, 0x01, 0x00. It ends with `pinData`=0, `pinClk`=1, `unlocked`=0 and `errCode`=0.
- R9: `startReq` and `exitReq` are accepted only while `busy` is 0. Requests made while busy have no effect on the byte stream or the pins.
- R10: `busy` is high from acceptance until the end of the sequence. `done` is a one-cycle pulse in the last busy cycle. `errFlag` equals (`errCode` != 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| startReq | input | 1 | Request link entry and unlock |
| exitReq | input | 1 | Request link exit |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | One-cycle end-of-sequence pulse |
| errFlag | output | 1 | Last sequence ended with an error |
| errCode | output | 3 | 0 none, 1 read error, 2 poll timeout |
| unlocked | output | 1 | Memory controller reported ready |
| pinOwn | output | 1 | Sequencer (not the transceiver) owns the pins |
| pinClk | output | 1 | Direct link clock level |
| pinData | output | 1 | Direct link data level |
| pinOe | output | 1 | Output enable for both link pins |
| txReq | output | 1 | Byte send request to the transceiver |
| txByte | output | 8 | Byte to send |
| txDone | input | 1 | Transceiver finished sending `txByte` |
| rxReq | output | 1 | Byte receive request to the transceiver |
| rxDone | input | 1 | Transceiver finished a receive |
| rxByte | input | 8 | Received status byte, valid with `rxDone` |
| rxErr | input | 1 | Receive failed (framing or parity), valid with `rxDone` |

## Verification
A corrupted script index or a wrong state shows up at once as a wrong byte on `txByte` at the next `txDone`. It can also show as an extra or missing pulse on `pinClk` before the first frame. A poll counter that is off by one shows only at the end of a timeout: the number of 0x80 sends no longer equals 256 when `done` rises with code 2. The bench therefore counts those sends exactly, and it also runs a case that succeeds on the 256th attempt. Error priority is visible one cycle after a failed read, because `done` must follow immediately with code 1.

// File: rtl/dlu_pkg.sv
package dlu_pkg;

  localparam int IDX_W        = 5;
  localparam int ENTER_LAST   = 12;
  localparam int EXIT_BASE    = 13;
  localparam int EXIT_LAST    = 20;
  localparam logic [7:0] POLL_CMD = 8'h80;
  localparam int READY_BIT    = 1;

  localparam logic [2:0] CODE_NONE    = 3'd0;
  localparam logic [2:0] CODE_RDERR   = 3'd1;
  localparam logic [2:0] CODE_TIMEOUT = 3'd2;

  typedef struct packed {
    logic       beginEntry;
    logic       beginExit;
    logic       raiseData;
    logic       clkLow;
    logic       clkHigh;
    logic       loadPulse;
    logic       decCnt;
    logic       incIdx;
    logic       incPoll;
    logic       selPoll;
    logic       setUnlock;
    logic       setErr;
    logic       parkPins;
    logic [2:0] errVal;
  } dluCtl_t;

  // Entry script (0..12) followed by exit script (13..20)
  function automatic logic [7:0] scriptByte(input logic [IDX_W-1:0] idx);
    logic [7:0] b;
    unique case (idx)
      5'd0:  b = 8'hC2;
      5'd1:  b = 8'h02;
      5'd2:  b = 8'hC1;
      5'd3:  b = 8'h59;
      5'd4:  b = 8'hE0;
      5'd5:  b = 8'hFF;
      5'd6:  b = 8'h88;
      5'd7:  b = 8'hD8;
      5'd8:  b = 8'hCD;
      5'd9:  b = 8'h45;
      5'd10: b = 8'hAB;
      5'd11: b = 8'h89;
      5'd12: b = 8'h12;
      5'd13: b = 8'hC1;
      5'd14: b = 8'h00;
      5'd15: b = 8'h4C;
      5'd16: b = 8'hCA;
      5'd17: b = 8'h01;
      5'd18: b = 8'h00;
      5'd19: b = 8'h01;
      5'd20: b = 8'h00;
      default: b = 8'h00;
    endcase
    return b;
  endfunction

endpackage

// File: rtl/dlu_dp.sv
module dlu_dp
  import dlu_pkg::*;
#(
  parameter int DELAY_CYCLES = 8,
  parameter int PULSE_COUNT  = 16,
  parameter int POLL_LIMIT   = 256
) (
  input  logic       clk,
  input  logic       rstN,
  input  dluCtl_t    ctl,
  input  logic [7:0] rxByte,
  output logic [7:0] txByte,
  output logic       cntZero,
  output logic       idxEnterLast,
  output logic       idxExitLast,
  output logic       pollAtLimit,
  output logic       rxReady,
  output logic       pinClk,
  output logic       pinData,
  output logic       pinOe,
  output logic       unlocked,
  output logic [2:0] errCode,
  output logic       errFlag
);

  localparam int CNT_MAX = (DELAY_CYCLES > PULSE_COUNT) ? DELAY_CYCLES : PULSE_COUNT;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam int POLL_W  = $clog2(POLL_LIMIT + 1);

  logic [CNT_W-1:0]  cnt;
  logic [IDX_W-1:0]  idx;
  logic [POLL_W-1:0] pollCnt;

  // Pin levels driven during entry and park
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pinData <= 1'b0;
      pinClk  <= 1'b1;
      pinOe   <= 1'b0;
    end else begin
      if (ctl.beginEntry) begin
        pinData <= 1'b0;
        pinClk  <= 1'b1;
        pinOe   <= 1'b1;
      end
      if (ctl.raiseData) pinData <= 1'b1;
      if (ctl.clkLow)    pinClk  <= 1'b0;
      if (ctl.clkHigh)   pinClk  <= 1'b1;
      if (ctl.parkPins) begin
        pinData <= 1'b0;
        pinClk  <= 1'b1;
      end
    end
  end

  // Shared settle / pulse counter
  always_ff @(posedge clk) begin
    if (!rstN)               cnt <= '0;
    else if (ctl.raiseData)  cnt <= CNT_W'(DELAY_CYCLES - 1);
    else if (ctl.loadPulse)  cnt <= CNT_W'(PULSE_COUNT - 1);
    else if (ctl.decCnt)     cnt <= cnt - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN)               idx <= '0;
    else if (ctl.beginEntry) idx <= '0;
    else if (ctl.beginExit)  idx <= IDX_W'(EXIT_BASE);
    else if (ctl.incIdx)     idx <= idx + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN)               pollCnt <= '0;
    else if (ctl.beginEntry) pollCnt <= '0;
    else if (ctl.incPoll)    pollCnt <= pollCnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      unlocked <= 1'b0;
      errCode  <= CODE_NONE;
    end else begin
      if (ctl.beginEntry || ctl.beginExit) begin
        unlocked <= 1'b0;
        errCode  <= CODE_NONE;
      end
      if (ctl.setUnlock) unlocked <= 1'b1;
      if (ctl.setErr)    errCode  <= ctl.errVal;
    end
  end

  assign txByte       = ctl.selPoll ? POLL_CMD : scriptByte(idx);
  assign cntZero      = (cnt == '0);
  assign idxEnterLast = (idx == IDX_W'(ENTER_LAST));
  assign idxExitLast  = (idx == IDX_W'(EXIT_LAST));
  assign pollAtLimit  = (pollCnt == POLL_W'(POLL_LIMIT));
  assign rxReady      = rxByte[READY_BIT];
  assign errFlag      = (errCode != CODE_NONE);

endmodule

// File: rtl/dlu_ctrl.sv
module dlu_ctrl
  import dlu_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    startReq,
  input  logic    exitReq,
  input  logic    txDone,
  input  logic    rxDone,
  input  logic    rxErr,
  input  logic    cntZero,
  input  logic    idxEnterLast,
  input  logic    idxExitLast,
  input  logic    pollAtLimit,
  input  logic    rxReady,
  output dluCtl_t ctl,
  output logic    txReq,
  output logic    rxReq,
  output logic    busy,
  output logic    done,
  output logic    pinOwn
);

  typedef enum logic [3:0] {
    S_IDLE, S_PRE, S_SETTLE, S_CLK_LO, S_CLK_HI,
    S_SEND, S_POLL_TX, S_POLL_RX, S_EXIT_TX, S_FINISH
  } state_t;

  state_t state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    ctl       = '0;
    txReq     = 1'b0;
    rxReq     = 1'b0;
    unique case (state)
      S_IDLE: begin
        if (startReq) begin
          ctl.beginEntry = 1'b1;
          nextState      = S_PRE;
        end else if (exitReq) begin
          ctl.beginExit  = 1'b1;
          nextState      = S_EXIT_TX;
        end
      end
      S_PRE: begin
        ctl.raiseData = 1'b1;
        nextState     = S_SETTLE;
      end
      S_SETTLE: begin
        if (cntZero) begin
          ctl.clkLow    = 1'b1;
          ctl.loadPulse = 1'b1;
          nextState     = S_CLK_LO;
        end else begin
          ctl.decCnt = 1'b1;
        end
      end
      S_CLK_LO: begin
        ctl.clkHigh = 1'b1;
        nextState   = S_CLK_HI;
      end
      S_CLK_HI: begin
        if (cntZero) begin
          nextState = S_SEND;
        end else begin
          ctl.clkLow = 1'b1;
          ctl.decCnt = 1'b1;
          nextState  = S_CLK_LO;
        end
      end
      S_SEND: begin
        txReq = 1'b1;
        if (txDone) begin
          if (idxEnterLast) nextState  = S_POLL_TX;
          else              ctl.incIdx = 1'b1;
        end
      end
      S_POLL_TX: begin
        txReq       = 1'b1;
        ctl.selPoll = 1'b1;
        if (txDone) begin
          ctl.incPoll = 1'b1;
          nextState   = S_POLL_RX;
        end
      end
      S_POLL_RX: begin
        rxReq = 1'b1;
        if (rxDone) begin
          if (rxErr) begin
            ctl.setErr = 1'b1;
            ctl.errVal = CODE_RDERR;
            nextState  = S_FINISH;
          end else if (rxReady) begin
            ctl.setUnlock = 1'b1;
            nextState     = S_FINISH;
          end else if (pollAtLimit) begin
            ctl.setErr = 1'b1;
            ctl.errVal = CODE_TIMEOUT;
            nextState  = S_FINISH;
          end else begin
            nextState = S_POLL_TX;
          end
        end
      end
      S_EXIT_TX: begin
        txReq = 1'b1;
        if (txDone) begin
          if (idxExitLast) begin
            ctl.parkPins = 1'b1;
            nextState    = S_FINISH;
          end else begin
            ctl.incIdx = 1'b1;
          end
        end
      end
      S_FINISH: nextState = S_IDLE;
      default:  nextState = S_IDLE;
    endcase
  end

  assign busy   = (state != S_IDLE);
  assign done   = (state == S_FINISH);
  assign pinOwn = !(state inside {S_SEND, S_POLL_TX, S_POLL_RX, S_EXIT_TX});

endmodule

// File: rtl/dbg_unlock_seq.sv
module dbg_unlock_seq
  import dlu_pkg::*;
#(
  parameter int DELAY_CYCLES = 8,
  parameter int PULSE_COUNT  = 16,
  parameter int POLL_LIMIT   = 256
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       startReq,
  input  logic       exitReq,
  output logic       busy,
  output logic       done,
  output logic       errFlag,
  output logic [2:0] errCode,
  output logic       unlocked,
  output logic       pinOwn,
  output logic       pinClk,
  output logic       pinData,
  output logic       pinOe,
  output logic       txReq,
  output logic [7:0] txByte,
  input  logic       txDone,
  output logic       rxReq,
  input  logic       rxDone,
  input  logic [7:0] rxByte,
  input  logic       rxErr
);

  dluCtl_t ctl;
  logic cntZero, idxEnterLast, idxExitLast, pollAtLimit, rxReady;

  dlu_ctrl u_ctrl (
    .clk, .rstN, .startReq, .exitReq, .txDone, .rxDone, .rxErr,
    .cntZero, .idxEnterLast, .idxExitLast, .pollAtLimit, .rxReady,
    .ctl, .txReq, .rxReq, .busy, .done, .pinOwn
  );

  dlu_dp #(
    .DELAY_CYCLES(DELAY_CYCLES),
    .PULSE_COUNT (PULSE_COUNT),
    .POLL_LIMIT  (POLL_LIMIT)
  ) u_dp (
    .clk, .rstN, .ctl, .rxByte, .txByte, .cntZero, .idxEnterLast,
    .idxExitLast, .pollAtLimit, .rxReady, .pinClk, .pinData, .pinOe,
    .unlocked, .errCode, .errFlag
  );

endmodule

// File: rtl/dbg_unlock_seq_chk.sv
module dbg_unlock_seq_chk #(
  parameter int POLL_LIMIT = 256
) (
  input logic       clk,
  input logic       rstN,
  input logic       startReq,
  input logic       busy,
  input logic       done,
  input logic [2:0] errCode,
  input logic       unlocked,
  input logic       pinOwn,
  input logic       pinClk,
  input logic       pinData,
  input logic       txReq,
  input logic [7:0] txByte,
  input logic       txDone,
  input logic       rxReq,
  input logic       rxDone,
  input logic       rxErr
);

  logic [15:0] pollSeen;

  always_ff @(posedge clk) begin
    if (!rstN)                                    pollSeen <= '0;
    else if (startReq && !busy)                   pollSeen <= '0;
    else if (txReq && txDone && txByte == 8'h80)  pollSeen <= pollSeen + 1'b1;
  end

  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    txReq && !txDone |=> txReq && $stable(txByte)); // R3
  AST_ONE_XFER: assert property (@(posedge clk) disable iff (!rstN)
    !(txReq && rxReq)); // R5
  AST_UNLOCK_CLEAN: assert property (@(posedge clk) disable iff (!rstN)
    $rose(unlocked) |-> errCode == 3'd0); // R5
  AST_PULSE_DATA_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    busy && pinOwn && $fell(pinClk) |-> pinData); // R2
  AST_TIMEOUT_COUNT: assert property (@(posedge clk) disable iff (!rstN)
    done && errCode == 3'd2 |-> pollSeen == 16'(POLL_LIMIT)); // R6
  AST_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    errCode <= 3'd2); // R6
  AST_READERR_STOP: assert property (@(posedge clk) disable iff (!rstN)
    rxReq && rxDone && rxErr |=> done && errCode == 3'd1); // R7
  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    busy && !done |=> busy); // R9
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done && !busy); // R10

endmodule

bind dbg_unlock_seq dbg_unlock_seq_chk #(.POLL_LIMIT(POLL_LIMIT)) u_chk (
  .clk, .rstN, .startReq, .busy, .done, .errCode, .unlocked, .pinOwn,
  .pinClk, .pinData, .txReq, .txByte, .txDone, .rxReq, .rxDone, .rxErr
);

// File: tb/dbg_unlock_seq_test.sv
`timescale 1ns/1ps
module dbg_unlock_seq_test;

  localparam int DELAY = 8;
  localparam int PULSES = 16;
  localparam int LIMIT = 256;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startReq = 1'b0, exitReq = 1'b0;
  logic busy, done, errFlag, unlocked, pinOwn, pinClk, pinData, pinOe;
  logic [2:0] errCode;
  logic txReq, rxReq;
  logic [7:0] txByte;
  logic txDone = 1'b0, rxDone = 1'b0, rxErr = 1'b0;
  logic [7:0] rxByte = 8'h00;

  always #2 clk = ~clk;

  dbg_unlock_seq #(.DELAY_CYCLES(DELAY), .PULSE_COUNT(PULSES), .POLL_LIMIT(LIMIT)) uut (
    .clk, .rstN, .startReq, .exitReq, .busy, .done, .errFlag, .errCode,
    .unlocked, .pinOwn, .pinClk, .pinData, .pinOe, .txReq, .txByte, .txDone,
    .rxReq, .rxDone, .rxByte, .rxErr
  );

  int nTests = 0, nFail = 0;
  logic [7:0] txLog [64];
  int txCount, pollSends, readCount;
  int readyAt, errAt;
  int pulseCnt, badData, gap, riseCyc, cyc;
  logic prevClk, prevData, prevOe;
  bit preOk, preSeen;

  localparam logic [7:0] ENTRY_SEQ [13] = '{8'hC2, 8'h02, 8'hC1, 8'h59, 8'hE0,
    8'hFF, 8'h88, 8'hD8, 8'hCD, 8'h45, 8'hAB, 8'h89, 8'h12};
  localparam logic [7:0] EXIT_SEQ [8] = '{8'hC1, 8'h00, 8'h4C, 8'hCA,
    8'h01, 8'h00, 8'h01, 8'h00};

  // readyAt, errAt, expected code, expected poll sends
  localparam int NROWS = 6;
  localparam int VEC [NROWS][4] = '{
    '{1,   0, 0, 1},
    '{5,   0, 0, 5},
    '{0,   3, 1, 3},
    '{0,   0, 2, 256},
    '{256, 0, 0, 256},
    '{1,   1, 1, 1}
  };

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // transceiver model: sends
  initial forever begin
    @(negedge clk);
    if (txReq) begin
      repeat (2) @(negedge clk);
      if (txCount < 64) txLog[txCount] = txByte;
      txCount++;
      if (txByte == 8'h80) pollSends++;
      txDone = 1'b1;
      @(negedge clk);
      txDone = 1'b0;
    end
  end

  // transceiver model: receives
  initial forever begin
    @(negedge clk);
    if (rxReq) begin
      @(negedge clk);
      readCount++;
      rxErr  = (readCount == errAt);
      rxByte = (readCount == readyAt) ? 8'h02 : 8'hFD;
      rxDone = 1'b1;
      @(negedge clk);
      rxDone = 1'b0;
      rxErr  = 1'b0;
    end
  end

  // pin monitor
  initial begin
    prevClk = 1'b1; prevData = 1'b0; prevOe = 1'b0; cyc = 0;
    forever begin
      @(negedge clk);
      cyc++;
      if (rstN && pinOe && !prevOe) begin
        preSeen = 1'b1;
        preOk   = (pinData == 1'b0) && (pinClk == 1'b1);
      end
      if (pinOwn && busy && pinData && !prevData) riseCyc = cyc;
      if (pinOwn && busy && prevClk && !pinClk) begin
        if (pulseCnt == 0) gap = cyc - riseCyc;
        pulseCnt++;
        if (!pinData) badData++;
      end
      prevClk = pinClk; prevData = pinData; prevOe = pinOe;
    end
  end

  task automatic clearLogs();
    txCount = 0; pollSends = 0; readCount = 0;
    pulseCnt = 0; badData = 0; gap = 0;
  endtask

  task automatic pulseReq(input bit s, input bit e);
    @(negedge clk);
    startReq = s; exitReq = e;
    @(negedge clk);
    startReq = 1'b0; exitReq = 1'b0;
  endtask

  task automatic waitDone();
    while (!done) @(negedge clk);
  endtask

  task automatic checkEntry(input int expCode, input int expPolls);
    check(errCode == 3'(expCode), "R5/R6/R7 code", int'(errCode), expCode);
    check(errFlag == (expCode != 0), "R10 errFlag", int'(errFlag), int'(expCode != 0));
    check(unlocked == (expCode == 0), "R5 unlocked", int'(unlocked), int'(expCode == 0));
    check(pollSends == expPolls, "R5/R6 poll sends", pollSends, expPolls);
    check(txCount == 13 + expPolls, "R4 byte count", txCount, 13 + expPolls);
    for (int i = 0; i < 13; i++)
      check(txLog[i] == ENTRY_SEQ[i], (i < 2) ? "R3 byte" : "R4 byte",
            int'(txLog[i]), int'(ENTRY_SEQ[i]));
    check(pulseCnt == PULSES, "R2 pulses", pulseCnt, PULSES);
    check(badData == 0, "R2 data high in pulses", badData, 0);
    check(gap >= DELAY, "R2 settle", gap, DELAY);
    @(negedge clk);
    check(!busy && !done, "R10 done one cycle", int'(busy) + int'(done), 0);
  endtask

  initial begin
    readyAt = 0; errAt = 0; riseCyc = 0; preOk = 1'b0; preSeen = 1'b0;
    clearLogs();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(!busy && !done && !errFlag && !unlocked, "R1 status", int'(busy|done|errFlag|unlocked), 0);
    check(errCode == 3'd0, "R1 errCode", int'(errCode), 0);
    check(!pinOe && !pinData && pinClk && pinOwn, "R1 pins",
          int'({pinOe, pinData, pinClk, pinOwn}), 4'b0011);
    check(!txReq && !rxReq, "R1 handshake", int'({txReq, rxReq}), 0);

    // vector table
    for (int r = 0; r < NROWS; r++) begin
      clearLogs();
      readyAt = VEC[r][0]; errAt = VEC[r][1];
      pulseReq(1'b1, 1'b0);
      waitDone();
      checkEntry(VEC[r][2], VEC[r][3]);
      if (r == 0) check(preSeen && preOk, "R2 preamble levels", int'(preOk), 1);
    end

    // R9: requests while busy are ignored
    clearLogs();
    readyAt = 2; errAt = 0;
    pulseReq(1'b1, 1'b0);
    repeat (3) @(negedge clk);
    startReq = 1'b1; exitReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0; exitReq = 1'b0;
    repeat (40) @(negedge clk);
    startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    waitDone();
    check(txCount == 15, "R9 no extra bytes", txCount, 15);
    checkEntry(0, 2);

    // R8 exit sequence
    clearLogs();
    pulseReq(1'b0, 1'b1);
    waitDone();
    check(txCount == 8, "R8 exit count", txCount, 8);
    for (int i = 0; i < 8; i++)
      check(txLog[i] == EXIT_SEQ[i], "R8 exit byte", int'(txLog[i]), int'(EXIT_SEQ[i]));
    check(!pinData && pinClk, "R8 park pins", int'({pinData, pinClk}), 1);
    check(!unlocked && errCode == 3'd0, "R8 status", int'(unlocked), 0);
    check(pulseCnt == 0, "R8 no pulses", pulseCnt, 0);

    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nTests++; nFail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule